// File: doc/BRIEF.md
# Duplicated Parity Memory with Hardware Reload

The block keeps every data word in two RAM copies, a primary and a replica, each word stored with one even-parity bit. A write lands in both copies in the same cycle. A read is served from the primary copy. When the primary word fails its parity check, an internal state machine keeps the requester stalled, looks up the same word in the replica and checks its parity. A good replica word is returned and also written back over the corrupted primary word. If the replica word is bad too, the read completes with an invalid mark and a sticky fatal flag is raised so that software can recover.

The requester sees a single request port with a busy/valid handshake. A request is taken in any cycle in which busy is low. While busy is high, new requests are ignored and must be held. A per-copy parity flip on the write port stores a deliberately wrong parity bit, so upsets can be created through the normal interface. A saturating counter reports how many words have been repaired.

Top module: `dup_parity_mem`

## Requirements
- R1: After reset, busy_o, rvalid_o, rerr_o and fatal_o are low and corr_cnt_o is zero. All stored words read back as zero with good parity.
- R2: An accepted write (req_i=1, we_i=1, busy_o=0 at a rising edge) stores wdata_i in both copies. The parity bit stored in each copy is the XOR of the data bits. It is inverted for the primary copy when inj_pri_i=1 and for the replica copy when inj_rep_i=1.
- R3: An accepted read whose primary word has good parity raises rvalid_o for exactly one cycle, at the second rising edge after acceptance, with the stored data on rdata_o and rerr_o low.
- R4: busy_o is high from the edge that accepts a read until the edge that raises rvalid_o. It is low in the rvalid_o cycle. Requests presented while busy_o is high are not accepted.
- R5: A read whose primary word fails parity while the replica word is good returns the replica data at the third rising edge after acceptance, with rerr_o low. The primary word is rewritten with good parity, so the next read of that address completes in two edges.
- R6: Each repair of R5 adds one to corr_cnt_o. The counter stops at 2^CNT_W-1.
- R7: A read whose primary and replica words both fail parity completes at the third edge with rvalid_o and rerr_o high. It sets fatal_o, which then stays high until reset. No repair is counted.
- R8: A write presented during a recovery is held off. The recovered read returns the old data, and the write takes effect only after busy_o falls.
- R9: A write completes in one edge, leaves busy_o low and never raises rvalid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | DATA_W | Write data |
| inj_pri_i | input | 1 | Store inverted parity in the primary copy on this write |
| inj_rep_i | input | 1 | Store inverted parity in the replica copy on this write |
| busy_o | output | 1 | Request not accepted while high |
| rvalid_o | output | 1 | Read data valid, one cycle |
| rdata_o | output | DATA_W | Read data |
| rerr_o | output | 1 | Returned data is invalid (both copies bad) |
| fatal_o | output | 1 | Sticky uncorrectable error |
| corr_cnt_o | output | CNT_W | Saturating repair count |

## Verification
The bench builds the block with its defaults: 8-bit words, 16 entries and a 3-bit repair counter. With only seven repairs to saturation, the counter ceiling is reached early, and a directed run of repairs drives it past that point. Sixteen entries make random addresses revisit words often. Corrupted primary words, words left with both copies corrupted, and words repaired earlier and then rewritten all come up inside a short random run.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CHK  = 2'd1,
    ST_REP  = 2'd2
  } dpm_state_e;

  function automatic logic even_par(input logic [63:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/dpm_copy.sv
module dpm_copy #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int WW    = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_flip_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_bad_o
);
  import dpm_pkg::*;

  logic [WW-1:0] row_q [DEPTH];
  logic [WW-1:0] wr_word;
  logic [WW-1:0] rd_word;

  always_comb begin
    wr_word = {even_par(64'(wr_data_i)) ^ wr_flip_i, wr_data_i};
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) row_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(g)) row_q[g] <= wr_word;
    end
  end

  assign rd_word   = row_q[rd_addr_i];
  assign rd_data_o = rd_word[DATA_W-1:0];
  assign rd_bad_o  = ^rd_word;

  // R2: a plain write is readable with good parity on the next cycle
  a_r2_clean_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_flip_i) ##1 (rd_addr_i == $past(wr_addr_i)) |-> !rd_bad_o);
endmodule

// File: rtl/dpm_corr_cnt.sv
module dpm_corr_cnt #(
  parameter int CNT_W = 3,
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r6_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CMAX) |=> (cnt_q == CMAX));
  a_r6_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/dpm_ctrl.sv
module dpm_ctrl #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] pri_data_i,
  input  logic              pri_bad_i,
  input  logic [DATA_W-1:0] rep_data_i,
  input  logic              rep_bad_i,
  output logic              acc_wr_o,
  output logic              fix_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rerr_o,
  output logic              fatal_o
);
  import dpm_pkg::*;

  dpm_state_e        state_q;
  logic [AW-1:0]     addr_q;
  logic              rvalid_q, rerr_q, fatal_q;
  logic [DATA_W-1:0] rdata_q;
  logic              acc;

  assign busy_o   = (state_q != ST_IDLE);
  assign acc      = req_i && !busy_o;
  assign acc_wr_o = acc && we_i;
  assign fix_o    = (state_q == ST_REP) && !rep_bad_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      rvalid_q <= 1'b0;
      rerr_q   <= 1'b0;
      rdata_q  <= '0;
      fatal_q  <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      rerr_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (acc && !we_i) begin
          addr_q  <= addr_i;
          state_q <= ST_CHK;
        end
        ST_CHK: if (!pri_bad_i) begin
          rvalid_q <= 1'b1;
          rdata_q  <= pri_data_i;
          state_q  <= ST_IDLE;
        end else begin
          state_q  <= ST_REP;
        end
        ST_REP: begin
          rvalid_q <= 1'b1;
          rdata_q  <= rep_data_i;
          rerr_q   <= rep_bad_i;
          if (rep_bad_i) fatal_q <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr_o = addr_q;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign rerr_o    = rerr_q;
  assign fatal_o   = fatal_q;

  a_r3_valid_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(busy_o));
  a_r4_no_valid_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !rvalid_o);
  a_r7_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
  a_r7_rerr_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> rvalid_o);
  a_r8_no_write_in_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_o |-> !acc_wr_o);
endmodule

// File: rtl/dup_parity_mem.sv
module dup_parity_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 3,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              inj_pri_i,
  input  logic              inj_rep_i,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rerr_o,
  output logic              fatal_o,
  output logic [CNT_W-1:0]  corr_cnt_o
);
  logic              acc_wr, fix;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] pri_data, rep_data;
  logic              pri_bad, rep_bad;

  logic              pri_wen, pri_flip;
  logic [AW-1:0]     pri_waddr;
  logic [DATA_W-1:0] pri_wdata;

  // primary write port is shared by requester writes and repairs
  assign pri_wen   = acc_wr || fix;
  assign pri_waddr = fix ? rd_addr  : addr_i;
  assign pri_wdata = fix ? rep_data : wdata_i;
  assign pri_flip  = fix ? 1'b0     : inj_pri_i;

  dpm_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .pri_data_i (pri_data),
    .pri_bad_i  (pri_bad),
    .rep_data_i (rep_data),
    .rep_bad_i  (rep_bad),
    .acc_wr_o   (acc_wr),
    .fix_o      (fix),
    .rd_addr_o  (rd_addr),
    .busy_o     (busy_o),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rdata_o),
    .rerr_o     (rerr_o),
    .fatal_o    (fatal_o)
  );

  dpm_copy #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pri (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (pri_wen),
    .wr_addr_i (pri_waddr),
    .wr_data_i (pri_wdata),
    .wr_flip_i (pri_flip),
    .rd_addr_i (rd_addr),
    .rd_data_o (pri_data),
    .rd_bad_o  (pri_bad)
  );

  dpm_copy #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rep (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (acc_wr),
    .wr_addr_i (addr_i),
    .wr_data_i (wdata_i),
    .wr_flip_i (inj_rep_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rep_data),
    .rd_bad_o  (rep_bad)
  );

  dpm_corr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (fix),
    .cnt_o  (corr_cnt_o)
  );

  // R5: a repair leaves the primary word clean for the following cycle
  a_r5_repair_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix |=> (busy_o || rvalid_o) && !$past(pri_flip));
endmodule

// File: tb/dup_parity_mem_test.sv
module dup_parity_mem_test;
  localparam int DW = 8, DEPTH = 16, CW = 3, AW = 4;
  localparam int CMAX = 7;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, ip = 0, ir = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, rvalid, rerr, fatal;
  logic [DW-1:0] rdata;
  logic [CW-1:0] cnt;

  int n_chk = 0, n_bad = 0, exp_cnt = 0;
  bit exp_fatal = 0, done = 0;
  logic [DW-1:0] m_data [DEPTH];
  bit m_pbad [DEPTH];
  bit m_rbad [DEPTH];

  always #10 clk = ~clk;

  dup_parity_mem #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .inj_pri_i(ip), .inj_rep_i(ir), .busy_o(busy),
    .rvalid_o(rvalid), .rdata_o(rdata), .rerr_o(rerr), .fatal_o(fatal),
    .corr_cnt_o(cnt));

  task automatic chk(input string req_tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit fp, input bit fr);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; ip = fp; ir = fr;
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0; ip = 0; ir = 0;
    chk("R9 write busy", busy, 0);
    chk("R9 write no rvalid", rvalid, 0);
    m_data[a] = d; m_pbad[a] = fp; m_rbad[a] = fr;
  endtask

  // read with expected values from the bench model
  task automatic do_read(input logic [AW-1:0] a);
    int cyc, exp_cyc, exp_err;
    @(negedge clk);
    req = 1; we = 0; addr = a;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    cyc = 1;
    chk("R4 busy after accept", busy, 1);
    while (!rvalid && cyc < 8) begin
      @(negedge clk);
      cyc++;
    end
    exp_cyc = m_pbad[a] ? 3 : 2;
    exp_err = (m_pbad[a] && m_rbad[a]) ? 1 : 0;
    chk("R3/R5 latency", cyc, exp_cyc);
    chk("R4 busy low at rvalid", busy, 0);
    chk("R7 rerr", rerr, exp_err);
    if (!exp_err) chk("R3/R5 data", rdata, m_data[a]);
    if (m_pbad[a] && !m_rbad[a]) begin
      exp_cnt = sat_inc(exp_cnt);
      m_pbad[a] = 0;
    end
    if (exp_err) exp_fatal = 1;
    @(negedge clk);
    chk("R3 rvalid one cycle", rvalid, 0);
    chk("R6 counter", cnt, exp_cnt);
    chk("R7 fatal", fatal, exp_fatal);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_pbad[i] = 0; m_rbad[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 rvalid", rvalid, 0);
    chk("R1 rerr", rerr, 0);
    chk("R1 fatal", fatal, 0);
    chk("R1 cnt", cnt, 0);
    do_read(4'd5);

    // R2/R3 clean write and read
    do_write(4'd1, 8'hA5, 0, 0);
    do_read(4'd1);
    // R5 primary corrupted, replica good, then clean re-read
    do_write(4'd2, 8'h3C, 1, 0);
    do_read(4'd2);
    do_read(4'd2);
    // R2 replica-only corruption is invisible to reads
    do_write(4'd3, 8'hFF, 0, 1);
    do_read(4'd3);

    // R4/R8 write held off during recovery
    do_write(4'd4, 8'h11, 1, 0);
    @(negedge clk);
    req = 1; we = 0; addr = 4'd4;
    @(posedge clk);
    @(negedge clk);
    we = 1; wdata = 8'h77;
    chk("R4 busy during recovery", busy, 1);
    begin
      int c = 1;
      while (!rvalid && c < 8) begin @(negedge clk); c++; end
      chk("R8 recovery latency", c, 3);
    end
    chk("R8 old data returned", rdata, 8'h11);
    exp_cnt = sat_inc(exp_cnt);
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0;
    chk("R8 held write accepted idle", busy, 0);
    m_data[4] = 8'h77; m_pbad[4] = 0; m_rbad[4] = 0;
    do_read(4'd4);

    // R6 saturation by repeated repairs
    for (int k = 0; k < 9; k++) begin
      do_write(4'd6, 8'(k * 13 + 1), 1, 0);
      do_read(4'd6);
    end
    chk("R6 saturated", cnt, CMAX);

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(DEPTH - 1));
      if ($urandom_range(1) == 0)
        do_write(a, DW'($urandom), $urandom_range(3) == 0, $urandom_range(5) == 0);
      else
        do_read(a);
    end

    // R7 both copies bad, fatal sticky
    do_write(4'd9, 8'h5A, 1, 1);
    do_read(4'd9);
    do_write(4'd9, 8'h5B, 0, 0);
    do_read(4'd9);
    chk("R7 fatal stays", fatal, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule